// File: doc/BRIEF.md
# Prioritized Interrupt Delivery Arbiter

This block keeps one pending bit for each of thirteen interrupt sources and, when the core asks for an interrupt, picks exactly one of them to hand over. Each source has its own enable rule. Some rules look at the machine-state enables: the external enable, the critical enable and the hypervisor-state bit. Others look at two partition-control bits: the hypervisor-decrementer enable and the bit that routes externals to the hypervisor. One rule also depends on whether a hypervisor mode exists at all. Among the sources whose rule passes, the one with the lowest index in a fixed ranking wins.

Sources raise their pending bits with one-cycle set pulses. A doorbell unit can withdraw the two doorbell bits. A power-save entry pulse throws away a pending hypervisor decrementer. Delivering a source usually clears its bit. The external and critical-external sources are level-like and stay pending after delivery. The decrementer clears on delivery only when a configuration flag says it should. The block also drives one combined request line toward the core, high whenever any bit is pending.

All outputs are plain control pins and there is no back-pressure. A delivery request is either answered with a one-cycle grant strobe and a cause code one clock later, or it is dropped when nothing is eligible.

Top module: `irq_arbiter`

## Requirements
- R1: Sources are indexed, highest priority first: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal. Bit k of `src_set` and of `pend` is source k. A request sampled at a clock edge makes `grant_vld` high for the following cycle, with `grant_cause` equal to the lowest eligible index.
- R2: Sources 0 and 1 are eligible whenever they are pending, regardless of every enable, and delivery clears them.
- R3: Source 2 is eligible only when `lpcr_hdice`=1 and either `msr_ee`=1 or `msr_hv`=0. Delivery clears it.
- R4: Source 3 is eligible when `msr_ee`=1, or when `hv_present`=1, `msr_hv`=0 and `lpcr_lpes0`=0. It stays pending after delivery.
- R5: Source 4 is eligible only when `msr_ce`=1. It stays pending after delivery.
- R6: Sources 5 to 12 are eligible only when `msr_ee`=1. Delivery clears each of them, except source 9.
- R7: Delivery clears source 9 only when `dec_clr_on_take`=1.
- R8: `irq_line` is high exactly when at least one bit of `pend` is set.
- R9: A `pwr_save` pulse clears pending source 2.
- R10: A request with no eligible source leaves `grant_vld` low and leaves `pend` unchanged.
- R11: A set pulse on a bit in the same cycle as any clear of that bit leaves the bit set.
- R12: `db_clr` clears source 10 and `cdb_clr` clears source 6. Neither affects any other bit.
- R13: After reset, `pend` is zero, `grant_vld` is low and `irq_line` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_set | input | 13 | Per-source set pulses |
| take_req | input | 1 | Core asks for one interrupt this cycle |
| msr_ee | input | 1 | External enable |
| msr_ce | input | 1 | Critical enable |
| msr_hv | input | 1 | Core is in hypervisor state |
| lpcr_hdice | input | 1 | Hypervisor decrementer enable |
| lpcr_lpes0 | input | 1 | Externals go to guest level when set |
| hv_present | input | 1 | A hypervisor mode exists |
| dec_clr_on_take | input | 1 | Decrementer clears on delivery |
| db_clr | input | 1 | Doorbell unit withdraws the doorbell |
| cdb_clr | input | 1 | Doorbell unit withdraws the critical doorbell |
| pwr_save | input | 1 | Power-save entry pulse |
| grant_vld | output | 1 | One-cycle delivery strobe |
| grant_cause | output | 4 | Index of the delivered source |
| pend | output | 13 | Pending bits |
| irq_line | output | 1 | Any interrupt pending |

## Verification
A wrong enable term shows up in the cycle after the request that exposes it. Either the grant arrives with a cause that names a lower-priority source, or a grant appears that should not, or an expected grant is missing. A wrong clear-on-delivery decision is visible on `pend` in that same cycle. It then stays wrong until the next set pulse or clear, and every later arbitration inherits the error. The sweep covers every single source under all 128 combinations of the seven control inputs, and every pair of sources under permissive enables. A long random run checks `grant_vld`, `grant_cause`, `pend` and `irq_line` against a model on every cycle.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;
  localparam int NSRC     = 13;
  localparam int CW       = $clog2(NSRC);
  localparam int S_RST    = 0;
  localparam int S_MCHK   = 1;
  localparam int S_HDEC   = 2;
  localparam int S_EXT    = 3;
  localparam int S_CEXT   = 4;
  localparam int S_WDOG   = 5;
  localparam int S_CDB    = 6;
  localparam int S_FIT    = 7;
  localparam int S_PIT    = 8;
  localparam int S_DEC    = 9;
  localparam int S_DB     = 10;
  localparam int S_PERF   = 11;
  localparam int S_THERM  = 12;
  localparam int FIRST_EE = S_WDOG;

  typedef struct packed {
    logic ee;
    logic ce;
    logic hv;
    logic hdice;
    logic lpes0;
    logic hv_present;
    logic dec_cod;
  } irq_ctl_t;
endpackage

// File: rtl/irq_elig.sv
`timescale 1ns/1ps
module irq_elig
  import irq_arb_pkg::*;
(
  input  logic [NSRC-1:0] pend_in,
  input  irq_ctl_t        ctl,
  output logic [NSRC-1:0] elig,
  output logic [NSRC-1:0] clr_on_take
);
  logic [NSRC-1:0] gate;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    if (g == S_RST || g == S_MCHK) begin : g_nmi
      assign gate[g]        = 1'b1;
      assign clr_on_take[g] = 1'b1;
    end else if (g == S_HDEC) begin : g_hdec
      assign gate[g]        = ctl.hdice & (ctl.ee | ~ctl.hv);
      assign clr_on_take[g] = 1'b1;
    end else if (g == S_EXT) begin : g_ext
      assign gate[g]        = ctl.ee | (ctl.hv_present & ~ctl.hv & ~ctl.lpes0);
      assign clr_on_take[g] = 1'b0;
    end else if (g == S_CEXT) begin : g_cext
      assign gate[g]        = ctl.ce;
      assign clr_on_take[g] = 1'b0;
    end else if (g == S_DEC) begin : g_dec
      assign gate[g]        = ctl.ee;
      assign clr_on_take[g] = ctl.dec_cod;
    end else begin : g_eegrp
      assign gate[g]        = ctl.ee;
      assign clr_on_take[g] = 1'b1;
    end
  end

  assign elig = pend_in & gate;
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
  parameter int N  = 13,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] elig,
  output logic [N-1:0] sel_oh,
  output logic         any,
  output logic [W-1:0] idx
);
  logic [N:0] blocked;
  assign blocked[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_chain
    assign sel_oh[g]      = elig[g] & ~blocked[g];
    assign blocked[g + 1] = blocked[g] | elig[g];
  end

  assign any = blocked[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_oh[i]) idx = idx | W'(i);
    end
  end
endmodule

// File: rtl/irq_pend.sv
`timescale 1ns/1ps
module irq_pend #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~clr) | set;
  end

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((q & $past(set)) == $past(set)))
    else $error("set pulse lost");

  p_clear_takes_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~set)) |=> ((q & $past(clr & ~set)) == '0))
    else $error("clear did not take");
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
  import irq_arb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic            take_req,
  input  logic            msr_ee,
  input  logic            msr_ce,
  input  logic            msr_hv,
  input  logic            lpcr_hdice,
  input  logic            lpcr_lpes0,
  input  logic            hv_present,
  input  logic            dec_clr_on_take,
  input  logic            db_clr,
  input  logic            cdb_clr,
  input  logic            pwr_save,
  output logic            grant_vld,
  output logic [CW-1:0]   grant_cause,
  output logic [NSRC-1:0] pend,
  output logic            irq_line
);
  irq_ctl_t        ctl;
  logic [NSRC-1:0] pend_q, elig, clr_on_take, sel_oh, clr_vec, side_clr;
  logic            any_elig, take;
  logic [CW-1:0]   sel_idx;

  assign ctl = '{ee: msr_ee, ce: msr_ce, hv: msr_hv, hdice: lpcr_hdice,
                 lpes0: lpcr_lpes0, hv_present: hv_present,
                 dec_cod: dec_clr_on_take};

  irq_elig u_elig (
    .pend_in    (pend_q),
    .ctl        (ctl),
    .elig       (elig),
    .clr_on_take(clr_on_take)
  );

  irq_pick #(.N(NSRC)) u_pick (
    .elig  (elig),
    .sel_oh(sel_oh),
    .any   (any_elig),
    .idx   (sel_idx)
  );

  assign take = take_req & any_elig;

  always_comb begin
    side_clr           = '0;
    side_clr[S_DB]     = db_clr;
    side_clr[S_CDB]    = cdb_clr;
    side_clr[S_HDEC]   = pwr_save;
  end

  assign clr_vec = (sel_oh & clr_on_take & {NSRC{take}}) | side_clr;

  irq_pend #(.N(NSRC)) u_pend (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (src_set),
    .clr  (clr_vec),
    .q    (pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_vld   <= 1'b0;
      grant_cause <= '0;
    end else begin
      grant_vld <= take;
      if (take) grant_cause <= sel_idx;
    end
  end

  assign pend     = pend_q;
  assign irq_line = |pend_q;

  p_pick_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh) && ((sel_oh & ~pend_q) == '0))
    else $error("picker selected a non-pending or several sources");

  p_vld_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_vld |-> $past(take_req))
    else $error("grant without request");

  p_ext_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_oh[S_EXT]) |=> pend_q[S_EXT])
    else $error("external cleared by delivery");

  p_cext_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sel_oh[S_CEXT]) |=> pend_q[S_CEXT])
    else $error("critical external cleared by delivery");

  p_hdec_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && grant_cause == CW'(S_HDEC)) |->
      ($past(lpcr_hdice) && ($past(msr_ee) || !$past(msr_hv))))
    else $error("hyp decrementer delivered while gated");

  p_ee_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_vld && grant_cause >= CW'(FIRST_EE)) |-> $past(msr_ee))
    else $error("EE-gated source delivered with EE low");

  p_psave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_save && !src_set[S_HDEC]) |=> !pend_q[S_HDEC])
    else $error("power save kept hyp decrementer");
endmodule

// File: tb/irq_arbiter_test.sv
`timescale 1ns/1ps
module irq_arbiter_test;
  localparam int N = 13;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_set = '0;
  logic         take_req = 1'b0;
  logic [6:0]   flags = '0;   // {dec_cod,hv_present,lpes0,hdice,hv,ce,ee}
  logic         db_clr = 1'b0, cdb_clr = 1'b0, pwr_save = 1'b0;
  logic         grant_vld;
  logic [3:0]   grant_cause;
  logic [N-1:0] pend;
  logic         irq_line;

  int total = 0;
  int bad   = 0;
  logic [N-1:0] mpend = '0;

  always #2 clk = ~clk;

  irq_arbiter uut (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .take_req(take_req),
    .msr_ee(flags[0]), .msr_ce(flags[1]), .msr_hv(flags[2]),
    .lpcr_hdice(flags[3]), .lpcr_lpes0(flags[4]), .hv_present(flags[5]),
    .dec_clr_on_take(flags[6]), .db_clr(db_clr), .cdb_clr(cdb_clr),
    .pwr_save(pwr_save), .grant_vld(grant_vld), .grant_cause(grant_cause),
    .pend(pend), .irq_line(irq_line)
  );

  function automatic bit may_go(int k, logic [6:0] f);
    case (k)
      0, 1:    return 1'b1;
      2:       return f[3] && (f[0] || !f[2]);
      3:       return f[0] || (f[5] && !f[2] && !f[4]);
      4:       return f[1];
      default: return f[0];
    endcase
  endfunction

  function automatic bit drops(int k, logic [6:0] f);
    if (k == 3 || k == 4) return 1'b0;
    if (k == 9) return f[6];
    return 1'b1;
  endfunction

  function automatic string tag_of(int k);
    case (k)
      0, 1:    return "R2";
      2:       return "R3";
      3:       return "R4";
      4:       return "R5";
      9:       return "R7";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    src_set = '0; take_req = 1'b0; db_clr = 1'b0; cdb_clr = 1'b0; pwr_save = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mpend = '0;
  endtask

  // Drives one cycle of stimulus, checks all outputs after the edge.
  task automatic tick(logic [N-1:0] s, bit rq, bit dbc, bit cdbc, bit ps, string ptag);
    int sel = -1;
    logic [N-1:0] nxt, clr;
    for (int k = 0; k < N; k++)
      if (sel < 0 && mpend[k] && may_go(k, flags)) sel = k;
    clr = '0;
    if (rq && sel >= 0 && drops(sel, flags)) clr[sel] = 1'b1;
    if (dbc)  clr[10] = 1'b1;
    if (cdbc) clr[6]  = 1'b1;
    if (ps)   clr[2]  = 1'b1;
    nxt = (mpend & ~clr) | s;
    src_set = s; take_req = rq; db_clr = dbc; cdb_clr = cdbc; pwr_save = ps;
    @(posedge clk);
    #1;
    if (rq && sel >= 0) begin
      chk(grant_vld == 1'b1, tag_of(sel), 32'(grant_vld), 1);
      chk(grant_cause == 4'(sel), "R1", 32'(grant_cause), 32'(sel));
    end else begin
      chk(grant_vld == 1'b0, "R10", 32'(grant_vld), 0);
    end
    chk(pend == nxt, ptag, 32'(pend), 32'(nxt));
    chk(irq_line == (|nxt), "R8", 32'(irq_line), 32'(|nxt));
    mpend = nxt;
    @(negedge clk);
    src_set = '0; take_req = 1'b0; db_clr = 1'b0; cdb_clr = 1'b0; pwr_save = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog act=hang exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    // R13: reset state
    chk(pend == '0, "R13", 32'(pend), 0);
    chk(grant_vld == 1'b0, "R13", 32'(grant_vld), 0);
    chk(irq_line == 1'b0, "R13", 32'(irq_line), 0);

    // Each source alone under every control combination (R2..R7, R10)
    for (int f = 0; f < 128; f++) begin
      for (int k = 0; k < N; k++) begin
        do_reset();
        flags = 7'(f);
        tick(13'(1) << k, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
        tick('0, 1'b1, 1'b0, 1'b0, 1'b0, tag_of(k));
        tick('0, 1'b1, 1'b0, 1'b0, 1'b0, tag_of(k));
      end
    end

    // R1: every pair under permissive controls
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        do_reset();
        flags = 7'h6B;
        tick((13'(1) << i) | (13'(1) << j), 1'b0, 1'b0, 1'b0, 1'b0, "R1");
        tick('0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
      end
    end

    // R11: set and delivery-clear of the same bit together
    do_reset();
    flags = 7'h00;
    tick(13'h001, 1'b0, 1'b0, 1'b0, 1'b0, "R11");
    tick(13'h001, 1'b1, 1'b0, 1'b0, 1'b0, "R11");
    chk(pend[0] == 1'b1, "R11", 32'(pend[0]), 1);

    // R12 / R11: doorbell clears, alone and against a set pulse
    do_reset();
    flags = 7'h00;
    tick(13'h1FFF, 1'b0, 1'b0, 1'b0, 1'b0, "R12");
    tick('0, 1'b0, 1'b1, 1'b0, 1'b0, "R12");
    chk(pend == 13'h1BFF, "R12", 32'(pend), 32'h1BFF);
    tick('0, 1'b0, 1'b0, 1'b1, 1'b0, "R12");
    chk(pend == 13'h1BBF, "R12", 32'(pend), 32'h1BBF);
    tick(13'h400, 1'b0, 1'b1, 1'b0, 1'b0, "R11");

    // R9: power-save drops only the hypervisor decrementer
    tick('0, 1'b0, 1'b0, 1'b0, 1'b1, "R9");
    chk(pend == 13'h1FBB, "R9", 32'(pend), 32'h1FBB);

    // Random mixture against the model
    do_reset();
    for (int c = 0; c < 6000; c++) begin
      logic [N-1:0] s;
      s = '0;
      for (int k = 0; k < N; k++) if ($urandom_range(0, 9) == 0) s[k] = 1'b1;
      if (c % 16 == 0) flags = 7'($urandom_range(0, 127));
      tick(s, $urandom_range(0, 2) != 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 7) == 0, $urandom_range(0, 15) == 0, "R12");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule